// File: doc/BRIEF.md
# Host bus front end for an ISA-style slave peripheral

This block sits between an ISA-style host bus and a peripheral that holds buffer RAM and I/O registers on chip. It works out, during a window after hardware reset, whether the device runs with an 8-bit or a 16-bit data path. Software may later force the width through a configuration write. The memory and I/O 16-bit chip-select indications are decoded combinationally from the raw, unlatched bus address. The block has no address-latch enable input at all, so an enable tied high on the board has no effect.

The memory address is captured on the leading (falling) edge of either memory strobe. A host that splits a 16-bit access into two 8-bit cycles therefore gets each half addressed by its own strobe. Any access that hits an internal window pulls the ready line low at once. The ready line is released by a small state machine in the local clock domain after two to three local clock periods. On reads the block drives the low byte lane, and drives the high byte lane as well when the matching 16-bit select is active.

The ready state machine has three states:
- RS_IDLE: waiting for an access. When the synchronized access seen is high, it moves to RS_DONE, or to RS_HOLD when extra wait periods are configured.
- RS_HOLD: counts the extra periods down, then moves to RS_DONE. It returns to RS_IDLE if the access ends first.
- RS_DONE: ready is released. It returns to RS_IDLE once the synchronized access seen has dropped.

The width window has two states:
- WS_OPEN: the strap is being sampled. The first configuration write moves it to WS_CLOSED.
- WS_CLOSED: the sampled strap is frozen until the next reset.

Top module: `isa_slave_biu`

## Requirements
- R1: After reset, `wide_mode` is 0 (8-bit) unless `width_strap_n` has been seen low while the width window is open. Once it has been seen low, `wide_mode` is 1 (16-bit).
- R2: A pulse on `cfg_we` writes the configuration bits. Bit 0 of `cfg_wdata` enables the width override, and bit 1 gives the forced width (1 = 16-bit). While the override is enabled, `wide_mode` follows bit 1 regardless of the strap.
- R3: The first `cfg_we` closes the width window. Later levels on `width_strap_n` do not change `wide_mode` until the next reset.
- R4: `memcs16_n` is low exactly when `wide_mode` is 1 and `bus_addr[19:11]` equals `mem_base`. It is combinational from the address and needs no strobe or latch enable.
- R5: `iocs16_n` is low exactly when `wide_mode` is 1 and `bus_addr[15:2]` equals `io_base`. It is combinational from the address.
- R6: While `wide_mode` is 0, `memcs16_n` and `iocs16_n` both stay high for every address.
- R7: A memory strobe in the memory window, or an I/O strobe in the I/O window, drives `rdy` low at once. `rdy` returns high within 2 to 3 `clk` periods of the strobe falling. A strobe outside both windows leaves `rdy` high.
- R8: `lat_addr` takes `bus_addr` on each falling edge of `memr_n` or `memw_n`, and holds it while the address changes during the strobe. I/O strobes do not change `lat_addr`.
- R9: On an internal read, `rd_oe_lo` is 1 and `rd_data[7:0]` carries `int_rdata[7:0]`. `rd_oe_hi` is 1 and `rd_data[15:8]` carries `int_rdata[15:8]` only when the matching 16-bit select is low. Otherwise `rd_oe_hi` is 0 and the high byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local crystal clock |
| rst_n | input | 1 | Hardware reset, active low |
| width_strap_n | input | 1 | Width strap pin; a low level selects 16-bit |
| cfg_we | input | 1 | Configuration write pulse (clk domain) |
| cfg_wdata | input | 2 | Bit 0 enables the override, bit 1 is the forced width |
| mem_base | input | 9 | Programmed memory window base (address bits 19:11) |
| io_base | input | 14 | Programmed I/O window base (address bits 15:2) |
| bus_addr | input | 20 | Raw host address |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| int_rdata | input | 16 | Read data from the internal resources |
| memcs16_n | output | 1 | Memory 16-bit select, active low |
| iocs16_n | output | 1 | I/O 16-bit select, active low |
| rdy | output | 1 | Host ready; low stretches the cycle |
| lat_addr | output | 20 | Address captured on a memory strobe edge |
| wide_mode | output | 1 | 1 = 16-bit bus mode |
| rd_data | output | 16 | Read data toward the host |
| rd_oe_lo | output | 1 | Drive the low byte lane |
| rd_oe_hi | output | 1 | Drive the high byte lane |

## Verification
The bench sweeps every value of the memory window field and every value of the I/O window field, in both widths. A decoder that compares the wrong bits, or that lets a select through in 8-bit mode, mis-asserts a select somewhere in those sweeps. The ready stretch is measured in 1 ns steps for strobes at every phase offset within a clock period. A design with a missing synchronizer stage, or an extra one, falls outside the 2-to-3-period band at some offset. Strap pulses that arrive after a configuration write catch a window that never closes. Split memory cycles with the address changing mid-strobe catch a latch that is transparent or that depends on the wrong strobe.

// File: rtl/isa_biu_pkg.sv
package isa_biu_pkg;

    // ready stretch controller
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_HOLD = 2'd1,
        RS_DONE = 2'd2
    } rdy_state_e;

    // width strap window
    typedef enum logic {
        WS_OPEN   = 1'b0,
        WS_CLOSED = 1'b1
    } win_state_e;

    localparam int CFG_W            = 2;
    localparam int CFG_OVR_EN_BIT   = 0;
    localparam int CFG_OVR_WIDE_BIT = 1;

endpackage

// File: rtl/isa_width_strap.sv
module isa_width_strap
    import isa_biu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             wide
);

    logic [SYNC_STAGES-1:0] strap_sync_q;
    logic                   strap_s;
    win_state_e             win_q, win_d;
    logic                   seen_low_q;
    logic                   ovr_en_q, ovr_wide_q;

    // strap pin is asynchronous to clk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strap_sync_q <= '1;
        else        strap_sync_q <= {strap_sync_q[SYNC_STAGES-2:0], strap_n};
    end
    assign strap_s = strap_sync_q[SYNC_STAGES-1];

    // window state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= WS_OPEN;
        else        win_q <= win_d;
    end

    // window next state
    always_comb begin
        win_d = win_q;
        unique case (win_q)
            WS_OPEN:   if (cfg_we) win_d = WS_CLOSED;
            WS_CLOSED: win_d = WS_CLOSED;
            default:   win_d = WS_OPEN;
        endcase
    end

    // sticky strap capture, only while the window is open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          seen_low_q <= 1'b0;
        else if (win_q == WS_OPEN && !strap_s) seen_low_q <= 1'b1;
    end

    // software override bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_en_q   <= 1'b0;
            ovr_wide_q <= 1'b0;
        end else if (cfg_we) begin
            ovr_en_q   <= cfg_wdata[CFG_OVR_EN_BIT];
            ovr_wide_q <= cfg_wdata[CFG_OVR_WIDE_BIT];
        end
    end

    always_comb begin
        wide = ovr_en_q ? ovr_wide_q : seen_low_q;
    end

    AST_STRAP_LOW_SETS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q == WS_OPEN && !strap_s && !ovr_en_q && !cfg_we) |=> wide); // R1

    AST_OVERRIDE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[CFG_OVR_EN_BIT]) |=> (wide == $past(cfg_wdata[CFG_OVR_WIDE_BIT]))); // R2

    AST_WINDOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q == WS_CLOSED) |=> $stable(seen_low_q)); // R3

endmodule

// File: rtl/isa_win_decode.sv
module isa_win_decode #(
    parameter int ADDR_W = 20,
    parameter int MEM_LO = 11,
    parameter int IO_HI  = 15,
    parameter int IO_LO  = 2
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [ADDR_W-MEM_LO-1:0] mem_base,
    input  logic [IO_HI-IO_LO:0]    io_base,
    input  logic                    wide,
    output logic                    mem_hit,
    output logic                    io_hit,
    output logic                    memcs16_n,
    output logic                    iocs16_n
);

    // compared straight from the bus, no latch in the path
    always_comb begin
        mem_hit   = (addr[ADDR_W-1:MEM_LO] == mem_base);
        io_hit    = (addr[IO_HI:IO_LO] == io_base);
        memcs16_n = !(wide && mem_hit);
        iocs16_n  = !(wide && io_hit);
    end

endmodule

// File: rtl/isa_rdy_stretch.sv
module isa_rdy_stretch
    import isa_biu_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int EXTRA_CYCLES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    output logic rdy
);

    localparam int CNT_W = $clog2(EXTRA_CYCLES + 2);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'((EXTRA_CYCLES > 0) ? EXTRA_CYCLES - 1 : 0);
    localparam int MAX_LOW = SYNC_STAGES + EXTRA_CYCLES + 1;
    localparam int LOW_W   = $clog2(MAX_LOW + 2) + 1;

    logic [SYNC_STAGES-1:0] acc_sync_q;
    logic                   acc_s;
    rdy_state_e             st_q, st_d;
    logic [CNT_W-1:0]       cnt_q;
    logic [LOW_W-1:0]       low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_sync_q <= '0;
        else        acc_sync_q <= {acc_sync_q[SYNC_STAGES-2:0], acc};
    end
    assign acc_s = acc_sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RS_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_IDLE: if (acc_s) st_d = (EXTRA_CYCLES > 0) ? RS_HOLD : RS_DONE;
            RS_HOLD: begin
                if (!acc_s)              st_d = RS_IDLE;
                else if (cnt_q == '0)    st_d = RS_DONE;
            end
            RS_DONE: if (!acc_s) st_d = RS_IDLE;
            default: st_d = RS_IDLE;
        endcase
    end

    // extra-period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (st_q == RS_IDLE)        cnt_q <= CNT_LOAD;
        else if (st_q == RS_HOLD && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // output process
    always_comb begin
        rdy = !(acc && st_q != RS_DONE);
    end

    // run length of rdy low, kept for the checks below
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               low_run_q <= '0;
        else if (rdy)             low_run_q <= '0;
        else if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
    end

    AST_STRETCH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        low_run_q <= LOW_W'(MAX_LOW)); // R7

    AST_STRETCH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdy) && acc) |-> (low_run_q >= LOW_W'(SYNC_STAGES + EXTRA_CYCLES))); // R7

endmodule

// File: rtl/isa_slave_biu.sv
module isa_slave_biu
    import isa_biu_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int MEM_LO       = 11,
    parameter int IO_HI        = 15,
    parameter int IO_LO        = 2,
    parameter int DATA_W       = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int EXTRA_CYCLES = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     width_strap_n,
    input  logic                     cfg_we,
    input  logic [CFG_W-1:0]         cfg_wdata,
    input  logic [ADDR_W-MEM_LO-1:0] mem_base,
    input  logic [IO_HI-IO_LO:0]     io_base,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     memr_n,
    input  logic                     memw_n,
    input  logic                     ior_n,
    input  logic                     iow_n,
    input  logic [DATA_W-1:0]        int_rdata,
    output logic                     memcs16_n,
    output logic                     iocs16_n,
    output logic                     rdy,
    output logic [ADDR_W-1:0]        lat_addr,
    output logic                     wide_mode,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_oe_lo,
    output logic                     rd_oe_hi
);

    localparam int LANE_W = DATA_W / 2;

    logic mem_hit, io_hit;
    logic mem_stb_n;
    logic acc;
    logic mem_rd, io_rd;

    isa_width_strap #(.SYNC_STAGES(SYNC_STAGES)) u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_n  (width_strap_n),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .wide     (wide_mode)
    );

    isa_win_decode #(
        .ADDR_W(ADDR_W), .MEM_LO(MEM_LO), .IO_HI(IO_HI), .IO_LO(IO_LO)
    ) u_dec (
        .addr     (bus_addr),
        .mem_base (mem_base),
        .io_base  (io_base),
        .wide     (wide_mode),
        .mem_hit  (mem_hit),
        .io_hit   (io_hit),
        .memcs16_n(memcs16_n),
        .iocs16_n (iocs16_n)
    );

    always_comb begin
        acc = (mem_hit && (!memr_n || !memw_n)) || (io_hit && (!ior_n || !iow_n));
    end

    isa_rdy_stretch #(
        .SYNC_STAGES(SYNC_STAGES), .EXTRA_CYCLES(EXTRA_CYCLES)
    ) u_rdy (
        .clk  (clk),
        .rst_n(rst_n),
        .acc  (acc),
        .rdy  (rdy)
    );

    // address captured on the leading edge of either memory strobe
    assign mem_stb_n = memr_n & memw_n;

    always_ff @(negedge mem_stb_n or negedge rst_n) begin
        if (!rst_n) lat_addr <= '0;
        else        lat_addr <= bus_addr;
    end

    // read byte lanes
    always_comb begin
        mem_rd   = mem_hit && !memr_n;
        io_rd    = io_hit && !ior_n;
        rd_oe_lo = mem_rd || io_rd;
        rd_oe_hi = (mem_rd && !memcs16_n) || (io_rd && !iocs16_n);
        rd_data  = '0;
        if (rd_oe_lo) rd_data[LANE_W-1:0]      = int_rdata[LANE_W-1:0];
        if (rd_oe_hi) rd_data[DATA_W-1:LANE_W] = int_rdata[DATA_W-1:LANE_W];
    end

    AST_NARROW_NO_CS16: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> (memcs16_n && iocs16_n)); // R6

    AST_HI_LANE_NEEDS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe_hi |-> (wide_mode && rd_oe_lo)); // R9

endmodule

// File: tb/sim_isa_slave_biu.sv
`timescale 1ns/1ps
module sim_isa_slave_biu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        width_strap_n = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_wdata = 2'b00;
    logic [8:0]  mem_base = 9'h0C3;
    logic [13:0] io_base = 14'h0ABC;
    logic [19:0] bus_addr = '0;
    logic        memr_n = 1'b1, memw_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
    logic [15:0] int_rdata = 16'hBEEF;
    logic        memcs16_n, iocs16_n, rdy, wide_mode, rd_oe_lo, rd_oe_hi;
    logic [19:0] lat_addr;
    logic [15:0] rd_data;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    isa_slave_biu u0 (
        .clk(clk), .rst_n(rst_n), .width_strap_n(width_strap_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .mem_base(mem_base), .io_base(io_base),
        .bus_addr(bus_addr), .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
        .int_rdata(int_rdata), .memcs16_n(memcs16_n), .iocs16_n(iocs16_n), .rdy(rdy),
        .lat_addr(lat_addr), .wide_mode(wide_mode), .rd_data(rd_data),
        .rd_oe_lo(rd_oe_lo), .rd_oe_hi(rd_oe_hi)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic strap_pulse();
        @(negedge clk);
        width_strap_n = 1'b0;
        repeat (3) @(negedge clk);
        width_strap_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic sweep_cs(input bit wide, input string rm, input string ri);
        for (int m = 0; m < 512; m++) begin
            bus_addr = {m[8:0], 11'h2A5};
            #1;
            chk(memcs16_n == !(wide && m[8:0] == mem_base), rm, memcs16_n, !(wide && m[8:0] == mem_base));
        end
        for (int i = 0; i < 16384; i++) begin
            bus_addr = {i[3:0], i[13:0], i[1:0]};
            #1;
            chk(iocs16_n == !(wide && i[13:0] == io_base), ri, iocs16_n, !(wide && i[13:0] == io_base));
        end
    endtask

    // R7: measure the ready stretch in 1 ns steps from the strobe edge
    task automatic stretch(input bit io, input int off);
        int n;
        @(posedge clk);
        #(off);
        if (io) begin
            bus_addr = {4'h3, io_base, 2'b01};
            iow_n = 1'b0;
        end else begin
            bus_addr = {mem_base, 11'h155};
            memr_n = 1'b0;
        end
        #0.5;
        chk(rdy == 1'b0, "R7 rdy drops on hit", rdy, 0);
        n = 0;
        while (!rdy && n < 100) begin
            #1;
            n++;
        end
        chk(n >= 16 && n <= 24, "R7 stretch ns", n, 24 - off);
        repeat (2) @(negedge clk);
        memr_n = 1'b1;
        iow_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        repeat (4) @(negedge clk);
        chk(wide_mode == 1'b0, "R1 no strap low -> 8-bit", wide_mode, 0);
        chk(rdy == 1'b1 && lat_addr == 20'h0, "R7 R8 reset state", {rdy, lat_addr}, 21'h100000);

        strap_pulse();
        chk(wide_mode == 1'b1, "R1 strap low -> 16-bit", wide_mode, 1);

        cfg_write(2'b00);
        chk(wide_mode == 1'b1, "R3 plain cfg write keeps strap", wide_mode, 1);
        strap_pulse();
        chk(wide_mode == 1'b1, "R3 after cfg write", wide_mode, 1);

        cfg_write(2'b01);
        chk(wide_mode == 1'b0, "R2 override to 8-bit", wide_mode, 0);
        sweep_cs(1'b0, "R6 memcs16_n narrow", "R6 iocs16_n narrow");

        cfg_write(2'b11);
        chk(wide_mode == 1'b1, "R2 override to 16-bit", wide_mode, 1);
        sweep_cs(1'b1, "R4 memcs16_n window", "R5 iocs16_n window");

        // second reset: strap high, window closed, then strap low is ignored
        do_reset();
        cfg_write(2'b00);
        strap_pulse();
        chk(wide_mode == 1'b0, "R3 strap ignored after cfg", wide_mode, 0);
        cfg_write(2'b11);

        for (int off = 1; off < 8; off++) stretch(1'b0, off);
        for (int off = 1; off < 8; off++) stretch(1'b1, off);

        // R7: miss leaves rdy high
        @(negedge clk);
        bus_addr = {~mem_base, 11'h155};
        memr_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            #7;
            chk(rdy == 1'b1, "R7 miss keeps rdy", rdy, 1);
        end
        memr_n = 1'b1;
        repeat (6) @(negedge clk);

        // R8: split cycle, two strobes each recapture
        bus_addr = 20'h12345;
        #2 memr_n = 1'b0;
        #2 bus_addr = 20'h0FFFF;
        #2 chk(lat_addr == 20'h12345, "R8 first half", lat_addr, 20'h12345);
        memr_n = 1'b1;
        #3 bus_addr = 20'h12346;
        #2 memw_n = 1'b0;
        #2 bus_addr = 20'h00000;
        #2 chk(lat_addr == 20'h12346, "R8 second half", lat_addr, 20'h12346);
        memw_n = 1'b1;
        #3 bus_addr = 20'h54321;
        #2 iow_n = 1'b0;
        #2 chk(lat_addr == 20'h12346, "R8 io strobe no capture", lat_addr, 20'h12346);
        iow_n = 1'b1;
        repeat (6) @(negedge clk);

        // R9: byte lanes
        bus_addr = {mem_base, 11'h010};
        memr_n = 1'b0;
        #2;
        chk(rd_oe_lo && rd_oe_hi && rd_data == 16'hBEEF, "R9 wide mem read",
            {rd_oe_lo, rd_oe_hi, rd_data}, {2'b11, 16'hBEEF});
        memr_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_addr = {4'h0, io_base, 2'b10};
        ior_n = 1'b0;
        #2;
        chk(rd_oe_lo && rd_oe_hi && rd_data == 16'hBEEF, "R9 wide io read",
            {rd_oe_lo, rd_oe_hi, rd_data}, {2'b11, 16'hBEEF});
        ior_n = 1'b1;
        repeat (6) @(negedge clk);
        cfg_write(2'b01);
        bus_addr = {mem_base, 11'h010};
        memr_n = 1'b0;
        #2;
        chk(rd_oe_lo && !rd_oe_hi && rd_data == 16'h00EF, "R9 narrow mem read",
            {rd_oe_lo, rd_oe_hi, rd_data}, {2'b10, 16'h00EF});
        memr_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_addr = {~mem_base, 11'h010};
        memr_n = 1'b0;
        #2;
        chk(!rd_oe_lo && !rd_oe_hi && rd_data == 16'h0000, "R9 miss read no lanes",
            {rd_oe_lo, rd_oe_hi, rd_data}, 18'h0);
        memr_n = 1'b1;
        repeat (4) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule